// File: doc/BRIEF.md
# Segmented kernel address mapper

This block is the first decision stage of an address translation unit. For every 32-bit virtual address it chooses one of three outcomes. Translation may be switched off entirely, and then the address passes through unchanged. A kernel-mode access may land in a segment that is direct-mapped, and then a 4-bit physical base replaces the top address bits. Everything else is handed to the paged lookup path that sits behind this block.

The address space is split into sixteen 256 MB segments, numbered by the top four address bits. A per-segment bit in the mapping configuration word marks which segments are direct-mapped for kernel accesses. The replacement base for each segment is a 4-bit field packed eight to a word in two kernel-base words: one word for the lower half of the segments and one for the upper half. The block holds no state. Its outputs follow its inputs within the same cycle, so one address can be evaluated every cycle.

Top module: `seg_mapper`

## Requirements
- R1: Translation is enabled exactly when bit 2 or bit 3 of `glb_cfg` is 1; all other bits of `glb_cfg` have no effect on any output.
- R2: With translation disabled, `route` is 0 (pass-through), `paddr` equals `vaddr` and `perm` is 3'b111, whatever the values of `user_mode`, `map_cfg` and the base words.
- R3: The segment number is `vaddr[31:27+1]`, that is bits 31 down to 28. With translation enabled, an access is direct-mapped (`route` = 1) only when `user_mode` is 0 and `map_cfg` bit number <segment> is 1.
- R4: Segments 0 to 7 take their base from `kbase_lo` and segments 8 to 15 from `kbase_hi`; the base is the 4-bit field starting at bit 4 × (segment mod 8) of that word.
- R5: A direct-mapped access gives `paddr` = {base, `vaddr[27:0]`} and `perm` = 3'b111.
- R6: With translation enabled, every user-mode access and every kernel access to a segment whose `map_cfg` bit is 0 gives `route` = 2 (paged lookup), with `paddr` = 0 and `perm` = 3'b000.
- R7: `route` never takes the value 3; `perm` bit 0 means read, bit 1 write and bit 2 execute.
- R8: The outputs are combinational: a change of any input is reflected at the outputs within the same clock cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| vaddr | input | 32 | Virtual address to classify |
| user_mode | input | 1 | 1 for a user-mode access, 0 for kernel mode |
| glb_cfg | input | 32 | Global configuration word; bits 2 and 3 enable translation |
| map_cfg | input | 32 | Per-segment direct-map enable bits, bit n for segment n |
| kbase_lo | input | 32 | Packed 4-bit bases for segments 0 to 7 |
| kbase_hi | input | 32 | Packed 4-bit bases for segments 8 to 15 |
| paddr | output | 32 | Physical address for pass-through or direct map, 0 otherwise |
| perm | output | 3 | Granted access rights {execute, write, read} |
| route | output | 2 | 0 pass-through, 1 segment-mapped, 2 needs page lookup |

## Verification
The assertions are immediate checks evaluated whenever the inputs settle, so they take for granted that every input carries a defined 0 or 1 and that all inputs of one evaluation are applied together. The stimulus changes all inputs at once away from the clock edge and samples one nanosecond later, so no check sees a half-applied combination. The checks also assume the mapping word is at least as wide as the segment count, which the parameter checks enforce at elaboration.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
   typedef enum logic [1:0] {
      ROUTE_BYPASS  = 2'd0,
      ROUTE_SEGMENT = 2'd1,
      ROUTE_PAGED   = 2'd2
   } route_e;

   // perm bit order: [0] read, [1] write, [2] execute
   localparam logic [2:0] PERM_ALL  = 3'b111;
   localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/segmap_enable.sv
module segmap_enable #(
   parameter int          CFG_W   = 32,
   parameter logic [31:0] EN_MASK = 32'h0000_000C
) (
   input  logic [CFG_W-1:0] cfg,
   output logic             enabled
);
   localparam logic [CFG_W-1:0] MASK_W = CFG_W'(EN_MASK);

   if (CFG_W < 1) begin : g_bad_width
      $error("segmap_enable: CFG_W must be positive");
   end

   assign enabled = |(cfg & MASK_W);
endmodule

// File: rtl/segmap_base_sel.sv
module segmap_base_sel #(
   parameter int SEG_BITS = 4,
   localparam int NUM_SEG = 2 ** SEG_BITS,
   localparam int HALF    = NUM_SEG / 2,
   localparam int BASE_W  = HALF * SEG_BITS
) (
   input  logic [SEG_BITS-1:0] seg,
   input  logic [BASE_W-1:0]   base_lo,
   input  logic [BASE_W-1:0]   base_hi,
   output logic [SEG_BITS-1:0] nibble
);
   logic [SEG_BITS-1:0] tab [NUM_SEG];

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_tab
      if (s < HALF) begin : g_low
         assign tab[s] = base_lo[(s % HALF) * SEG_BITS +: SEG_BITS];
      end else begin : g_high
         assign tab[s] = base_hi[(s % HALF) * SEG_BITS +: SEG_BITS];
      end
   end

   assign nibble = tab[seg];
endmodule

// File: rtl/segmap_route.sv
module segmap_route
   import segmap_pkg::*;
#(
   parameter int SEG_BITS = 4,
   parameter int CFG_W    = 32,
   localparam int IDX_W   = $clog2(CFG_W)
) (
   input  logic                enabled,
   input  logic                user_mode,
   input  logic [SEG_BITS-1:0] seg,
   input  logic [CFG_W-1:0]    map_cfg,
   output route_e              route
);
   logic [IDX_W-1:0] idx;
   logic             seg_on;

   assign idx    = IDX_W'(seg);
   assign seg_on = map_cfg[idx];

   always_comb begin
      if (!enabled)                 route = ROUTE_BYPASS;
      else if (!user_mode && seg_on) route = ROUTE_SEGMENT;
      else                          route = ROUTE_PAGED;
   end
endmodule

// File: rtl/seg_mapper.sv
module seg_mapper
   import segmap_pkg::*;
#(
   parameter int          ADDR_W   = 32,
   parameter int          SEG_BITS = 4,
   parameter int          CFG_W    = 32,
   parameter logic [31:0] EN_MASK  = 32'h0000_000C,
   localparam int NUM_SEG = 2 ** SEG_BITS,
   localparam int BASE_W  = (NUM_SEG / 2) * SEG_BITS,
   localparam int OFF_W   = ADDR_W - SEG_BITS
) (
   input  logic [ADDR_W-1:0] vaddr,
   input  logic              user_mode,
   input  logic [CFG_W-1:0]  glb_cfg,
   input  logic [CFG_W-1:0]  map_cfg,
   input  logic [BASE_W-1:0] kbase_lo,
   input  logic [BASE_W-1:0] kbase_hi,
   output logic [ADDR_W-1:0] paddr,
   output logic [2:0]        perm,
   output logic [1:0]        route
);
   if (SEG_BITS < 1 || SEG_BITS >= ADDR_W) begin : g_bad_seg
      $error("seg_mapper: SEG_BITS must lie between 1 and ADDR_W-1");
   end
   if (CFG_W < NUM_SEG) begin : g_bad_cfg
      $error("seg_mapper: CFG_W must cover one bit per segment");
   end

   logic                en;
   logic [SEG_BITS-1:0] seg;
   logic [SEG_BITS-1:0] nib;
   logic [OFF_W-1:0]    offset;
   route_e              rsel;

   assign seg    = vaddr[ADDR_W-1 -: SEG_BITS];
   assign offset = vaddr[OFF_W-1:0];

   segmap_enable #(.CFG_W(CFG_W), .EN_MASK(EN_MASK)) u_en (
      .cfg     (glb_cfg),
      .enabled (en)
   );

   segmap_base_sel #(.SEG_BITS(SEG_BITS)) u_base (
      .seg     (seg),
      .base_lo (kbase_lo),
      .base_hi (kbase_hi),
      .nibble  (nib)
   );

   segmap_route #(.SEG_BITS(SEG_BITS), .CFG_W(CFG_W)) u_route (
      .enabled   (en),
      .user_mode (user_mode),
      .seg       (seg),
      .map_cfg   (map_cfg),
      .route     (rsel)
   );

   always_comb begin
      unique case (rsel)
         ROUTE_BYPASS: begin
            paddr = vaddr;
            perm  = PERM_ALL;
         end
         ROUTE_SEGMENT: begin
            paddr = {nib, offset};
            perm  = PERM_ALL;
         end
         default: begin
            paddr = '0;
            perm  = PERM_NONE;
         end
      endcase
   end

   assign route = rsel;
endmodule

// File: rtl/seg_mapper_chk.sv
module seg_mapper_chk #(
   parameter int ADDR_W   = 32,
   parameter int SEG_BITS = 4,
   parameter int CFG_W    = 32,
   parameter int BASE_W   = 32
) (
   input logic [ADDR_W-1:0] vaddr,
   input logic              user_mode,
   input logic [CFG_W-1:0]  glb_cfg,
   input logic [CFG_W-1:0]  map_cfg,
   input logic [BASE_W-1:0] kbase_lo,
   input logic [BASE_W-1:0] kbase_hi,
   input logic [ADDR_W-1:0] paddr,
   input logic [2:0]        perm,
   input logic [1:0]        route
);
   localparam int OFF_W = ADDR_W - SEG_BITS;

   always_comb begin
      // R7: only three route codes exist
      p_code_valid_r7: assert (route != 2'd3)
         else $error("route code 3 produced");
      // R2: with both enable bits clear the address passes through
      if (glb_cfg[3:2] == 2'b00) begin
         p_bypass_r2: assert (route == 2'd0 && paddr == vaddr && perm == 3'b111)
            else $error("disabled access not passed through");
      end
      // R6: any user access with translation on goes to page lookup
      if (glb_cfg[3:2] != 2'b00 && user_mode) begin
         p_user_paged_r6: assert (route == 2'd2 && perm == 3'b000 && paddr == '0)
            else $error("user access not routed to page lookup");
      end
      // R5: a mapped access keeps its offset and gets full rights
      if (route == 2'd1) begin
         p_seg_offset_r5: assert (paddr[OFF_W-1:0] == vaddr[OFF_W-1:0] && perm == 3'b111)
            else $error("mapped access lost offset or rights");
         // R3: mapping only happens for kernel accesses
         p_seg_kernel_r3: assert (!user_mode)
            else $error("user access was direct-mapped");
      end
      // R1: bits outside the enable field never turn translation on
      if (route != 2'd0) begin
         p_enable_src_r1: assert (glb_cfg[3:2] != 2'b00)
            else $error("translation active without enable bits");
      end
   end

   // operand widths tie the base words into the checked interface
   logic unused_bases;
   assign unused_bases = ^{kbase_lo, kbase_hi, map_cfg};
endmodule

bind seg_mapper seg_mapper_chk #(
   .ADDR_W   (ADDR_W),
   .SEG_BITS (SEG_BITS),
   .CFG_W    (CFG_W),
   .BASE_W   (BASE_W)
) u_chk (
   .vaddr     (vaddr),
   .user_mode (user_mode),
   .glb_cfg   (glb_cfg),
   .map_cfg   (map_cfg),
   .kbase_lo  (kbase_lo),
   .kbase_hi  (kbase_hi),
   .paddr     (paddr),
   .perm      (perm),
   .route     (route)
);

// File: tb/seg_mapper_test.sv
module seg_mapper_test;
   logic        clk = 1'b0;
   logic [31:0] vaddr = '0;
   logic        user_mode = 1'b0;
   logic [31:0] glb_cfg = '0;
   logic [31:0] map_cfg = '0;
   logic [31:0] kbase_lo = '0;
   logic [31:0] kbase_hi = '0;
   logic [31:0] paddr;
   logic [2:0]  perm;
   logic [1:0]  route;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   seg_mapper uut (
      .vaddr     (vaddr),
      .user_mode (user_mode),
      .glb_cfg   (glb_cfg),
      .map_cfg   (map_cfg),
      .kbase_lo  (kbase_lo),
      .kbase_hi  (kbase_hi),
      .paddr     (paddr),
      .perm      (perm),
      .route     (route)
   );

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // expected outputs derived from the requirement text
   task automatic expect_all(input string req);
      logic        en;
      logic [3:0]  s;
      logic [3:0]  b;
      logic [31:0] ep;
      logic [2:0]  eperm;
      logic [1:0]  er;
      en = glb_cfg[2] | glb_cfg[3];
      s  = vaddr[31:28];
      b  = (s < 4'd8) ? kbase_lo[s[2:0]*4 +: 4] : kbase_hi[s[2:0]*4 +: 4];
      if (!en) begin
         er = 2'd0; ep = vaddr; eperm = 3'b111;
      end else if (!user_mode && map_cfg[s]) begin
         er = 2'd1; ep = {b, vaddr[27:0]}; eperm = 3'b111;
      end else begin
         er = 2'd2; ep = 32'h0; eperm = 3'b000;
      end
      check(req, "route", {30'h0, route}, {30'h0, er});
      check(req, "paddr", paddr, ep);
      check(req, "perm", {29'h0, perm}, {29'h0, eperm});
   endtask

   task automatic apply(input logic [31:0] va, input logic um, input logic [31:0] g,
                        input logic [31:0] m, input logic [31:0] lo, input logic [31:0] hi);
      @(negedge clk);
      vaddr = va; user_mode = um; glb_cfg = g;
      map_cfg = m; kbase_lo = lo; kbase_hi = hi;
      #1;
   endtask

   task automatic t_idle;
      apply('0, 1'b0, '0, '0, '0, '0);
      check("R2", "idle route", {30'h0, route}, 32'h0);
      check("R2", "idle perm", {29'h0, perm}, 32'h7);
      check("R2", "idle paddr", paddr, 32'h0);
   endtask

   task automatic t_enable_bits_r1;
      apply(32'h3123_4567, 1'b0, 32'h0000_0004, 32'hFFFF_FFFF, 32'hFEDC_BA98, 32'h0123_4567);
      check("R1", "bit2 enables", {30'h0, route}, 32'h1);
      apply(32'h3123_4567, 1'b0, 32'h0000_0008, 32'hFFFF_FFFF, 32'hFEDC_BA98, 32'h0123_4567);
      check("R1", "bit3 enables", {30'h0, route}, 32'h1);
      apply(32'h3123_4567, 1'b0, 32'hFFFF_FFF3, 32'hFFFF_FFFF, 32'hFEDC_BA98, 32'h0123_4567);
      check("R1", "other bits ignored", {30'h0, route}, 32'h0);
      expect_all("R1");
   endtask

   task automatic t_bypass_r2;
      apply(32'hDEAD_BEEF, 1'b1, 32'h0, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222);
      expect_all("R2");
      check("R2", "user bypass paddr", paddr, 32'hDEAD_BEEF);
      apply(32'h8000_0010, 1'b0, 32'h0000_0001, 32'hFFFF_FFFF, 32'h1111_1111, 32'h2222_2222);
      check("R2", "kernel bypass paddr", paddr, 32'h8000_0010);
   endtask

   task automatic t_all_segments_r4;
      for (int s = 0; s < 16; s++) begin
         apply({s[3:0], 28'h0ABC_DEF ^ 28'(s)}, 1'b0, 32'hC, 32'h0000_FFFF,
               32'hFEDC_BA98, 32'h0123_4567);
         expect_all("R4");
      end
      // explicit: segment 9 -> field at bits 7:4 of kbase_hi = 6
      apply(32'h9000_1234, 1'b0, 32'h4, 32'h0000_FFFF, 32'hFEDC_BA98, 32'h0123_4567);
      check("R5", "seg9 paddr", paddr, 32'h6000_1234);
      check("R5", "seg9 perm", {29'h0, perm}, 32'h7);
      // segment 2 -> bits 11:8 of kbase_lo = A
      apply(32'h2FFF_FFFF, 1'b0, 32'h4, 32'h0000_FFFF, 32'hFEDC_BA98, 32'h0123_4567);
      check("R4", "seg2 paddr", paddr, 32'hAFFF_FFFF);
   endtask

   task automatic t_map_bit_r3;
      apply(32'h5000_0100, 1'b0, 32'h8, 32'h0000_0020, 32'h0, 32'h0);
      check("R3", "seg5 mapped", {30'h0, route}, 32'h1);
      apply(32'h4000_0100, 1'b0, 32'h8, 32'h0000_0020, 32'h0, 32'h0);
      check("R3", "seg4 not mapped", {30'h0, route}, 32'h2);
      apply(32'h6000_0100, 1'b0, 32'h8, 32'h0000_0020, 32'h0, 32'h0);
      expect_all("R3");
   endtask

   task automatic t_paged_r6;
      apply(32'hA123_4567, 1'b1, 32'hC, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
      check("R6", "user route", {30'h0, route}, 32'h2);
      check("R6", "user paddr", paddr, 32'h0);
      check("R6", "user perm", {29'h0, perm}, 32'h0);
      apply(32'hF000_0000, 1'b0, 32'hC, 32'h0000_7FFF, 32'h0, 32'h0);
      check("R6", "seg15 unmapped route", {30'h0, route}, 32'h2);
      check("R7", "no code 3", {31'h0, route == 2'd3}, 32'h0);
   endtask

   task automatic t_comb_r8;
      apply(32'h1000_0000, 1'b0, 32'h4, 32'h0000_0002, 32'h0000_0050, 32'h0);
      check("R8", "first value", paddr, 32'h5000_0000);
      #1 vaddr = 32'h1000_0044;
      #1 check("R8", "same-cycle update", paddr, 32'h5000_0044);
      user_mode = 1'b1;
      #0.5 check("R8", "same-cycle user", {30'h0, route}, 32'h2);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      t_idle();
      t_enable_bits_r1();
      t_bypass_r2();
      t_all_segments_r4();
      t_map_bit_r3();
      t_paged_r6();
      t_comb_r8();
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule